// File: doc/BRIEF.md
# Paired-Instruction Fetch Sequencer

This block is the fetch front end of a small accumulator machine. Each 40-bit memory word packs two 20-bit instructions, a left one and a right one. Every instruction is an 8-bit opcode and a 12-bit operand address. The sequencer drives a word-addressed read port from an internal memory address register. It captures the returned word in a memory buffer register and hands the left instruction to the execute stage. The right instruction is parked in a buffer, so the following issue needs no memory read. The program counter counts instruction pairs, not single instructions, so it advances once per fetched word.

Issue uses a valid/ready handshake. The execute stage may request a branch in the same cycle in which it accepts an instruction. The request carries a 12-bit target word address and a side bit, which says whether execution continues at the left or the right half of that word.

Top module: `pair_fetch_seq`

## Requirements
- R1: A synchronous active-high `rst` clears the pair counter to 0, empties the right-half buffer and drops `iss_valid`. The first read after reset is at address 0.
- R2: The word layout is fixed. Word bits [39:32] are the left opcode and [31:20] the left address. Bits [19:12] are the right opcode and [11:0] the right address. Bit 39 is the first, most significant bit.
- R3: From a fetched word, the left instruction is issued first. The right instruction is issued next, from the buffer, with no memory read in between.
- R4: The pair counter advances by one for each word fetched and wraps from 0xFFF to 0x000. Straight-line code reads addresses 0, 1, 2, … once each.
- R5: A read is a single-cycle pulse on `mem_rd` with the address on `mem_addr`. The word on `mem_rdata` one cycle later is the one captured.
- R6: While `iss_valid` is high and `iss_ready` is low, `iss_valid`, `iss_opcode` and `iss_addr` hold their values.
- R7: A branch with `br_right`=0 fetches the target word and issues its left instruction, then its right one.
- R8: A branch with `br_right`=1 fetches the target word, issues only its right instruction and then continues with the word at target+1. The target word costs exactly one read.
- R9: A taken branch discards a right instruction waiting in the buffer.
- R10: `br_valid` is taken into account only in a cycle where `iss_valid` and `iss_ready` are both high; at any other time it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Word address for memory reads |
| mem_rd | output | 1 | Read strobe, one cycle |
| mem_rdata | input | 40 | Word returned one cycle after the strobe |
| iss_valid | output | 1 | An instruction is offered to execute |
| iss_ready | input | 1 | Execute accepts the offered instruction |
| iss_opcode | output | 8 | Opcode of the offered instruction |
| iss_addr | output | 12 | Address field of the offered instruction |
| br_valid | input | 1 | Branch request, taken with an accept |
| br_target | input | 12 | Branch target word address |
| br_right | input | 1 | 1: resume at the right half of the target |

## Verification
Straight-line code is swept across sixteen consecutive words. Every field of each word is derived arithmetically from its address, so a swapped half, a swapped field or a skipped address shows up as a wrong value. The accept delay varies from word to word. Stray branch requests are driven during the stalls; they separate a correct hold-and-ignore from a design that drifts or takes the branch early. Branches to the left half, to the right half and to the top address are then exercised. The read count is checked against the number of words, which tells a buffered right issue apart from a re-fetch.

// File: rtl/pair_fetch_seq.sv
module pair_fetch_seq #(
  parameter int OPC_W  = 8,
  parameter int ADDR_W = 12
) (
  input  logic                            clk,
  input  logic                            rst,
  output logic [ADDR_W-1:0]               mem_addr,
  output logic                            mem_rd,
  input  logic [2*(OPC_W+ADDR_W)-1:0]     mem_rdata,
  output logic                            iss_valid,
  input  logic                            iss_ready,
  output logic [OPC_W-1:0]                iss_opcode,
  output logic [ADDR_W-1:0]               iss_addr,
  input  logic                            br_valid,
  input  logic [ADDR_W-1:0]               br_target,
  input  logic                            br_right
);
  localparam int INS_W  = OPC_W + ADDR_W;
  localparam int WORD_W = 2 * INS_W;

  typedef enum logic [2:0] {S_NEXT, S_RD, S_CAP, S_DEC, S_HOLD} st_t;

  st_t               st;
  logic [ADDR_W-1:0] pc, mar, ar;
  logic [WORD_W-1:0] mbr;
  logic [OPC_W-1:0]  ir;
  logic [INS_W-1:0]  ibr;
  logic              ibr_v, iss_v, side_r;

  wire [INS_W-1:0] left_ins  = mbr[WORD_W-1 -: INS_W];
  wire [INS_W-1:0] right_ins = mbr[INS_W-1:0];
  wire             take      = iss_v && iss_ready;

  assign mem_addr   = mar;
  assign mem_rd     = (st == S_RD);
  assign iss_valid  = iss_v;
  assign iss_opcode = ir;
  assign iss_addr   = ar;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_NEXT;
      pc     <= '0;
      mar    <= '0;
      mbr    <= '0;
      ir     <= '0;
      ar     <= '0;
      ibr    <= '0;
      ibr_v  <= 1'b0;
      iss_v  <= 1'b0;
      side_r <= 1'b0;
    end else begin
      case (st)
        S_NEXT: begin
          if (ibr_v) begin
            {ir, ar} <= ibr;
            ibr_v    <= 1'b0;
            iss_v    <= 1'b1;
            st       <= S_HOLD;
          end else begin
            mar <= pc;
            st  <= S_RD;
          end
        end
        S_RD: st <= S_CAP;
        S_CAP: begin
          mbr <= mem_rdata;
          pc  <= pc + 1'b1;
          st  <= S_DEC;
        end
        S_DEC: begin
          if (side_r) begin
            {ir, ar} <= right_ins;
            ibr_v    <= 1'b0;
            side_r   <= 1'b0;
          end else begin
            {ir, ar} <= left_ins;
            ibr      <= right_ins;
            ibr_v    <= 1'b1;
          end
          iss_v <= 1'b1;
          st    <= S_HOLD;
        end
        S_HOLD: begin
          if (take) begin
            iss_v <= 1'b0;
            st    <= S_NEXT;
            if (br_valid) begin
              pc     <= br_target;
              ibr_v  <= 1'b0;
              side_r <= br_right;
            end
          end
        end
        default: st <= S_NEXT;
      endcase
    end
  end
endmodule

// File: rtl/pair_fetch_chk.sv
module pair_fetch_chk #(
  parameter int OPC_W  = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_rd,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic [OPC_W-1:0]  iss_opcode,
  input logic [ADDR_W-1:0] iss_addr
);
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
    iss_valid && !iss_ready |=> iss_valid && $stable(iss_opcode) && $stable(iss_addr));

  assert_read_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  assert_no_read_during_issue_R3: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && iss_valid));

  assert_accept_clears_valid_R6: assert property (@(posedge clk) disable iff (rst)
    iss_valid && iss_ready |=> !iss_valid);
endmodule

bind pair_fetch_seq pair_fetch_chk #(.OPC_W(OPC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mem_rd(mem_rd), .iss_valid(iss_valid),
  .iss_ready(iss_ready), .iss_opcode(iss_opcode), .iss_addr(iss_addr)
);

// File: tb/tb_pair_fetch_seq.sv
module tb_pair_fetch_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic        mem_rd;
  logic [39:0] mem_rdata = '0;
  logic        iss_valid;
  logic        iss_ready = 1'b0;
  logic [7:0]  iss_opcode;
  logic [11:0] iss_addr;
  logic        br_valid = 1'b0;
  logic [11:0] br_target = '0;
  logic        br_right = 1'b0;

  int total = 0, bad = 0, rd_cnt = 0;
  logic [11:0] last_rd = '0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  pair_fetch_seq dut (.*);

  function automatic logic [7:0]  lop(input logic [11:0] a); return a[7:0] ^ 8'hC3; endfunction
  function automatic logic [11:0] lad(input logic [11:0] a); return a ^ 12'h9A5; endfunction
  function automatic logic [7:0]  rop(input logic [11:0] a); return a[11:4] + 8'h11; endfunction
  function automatic logic [11:0] rad(input logic [11:0] a); return ~a; endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= {lop(mem_addr), lad(mem_addr), rop(mem_addr), rad(mem_addr)};
    if (!rst && mem_rd) begin rd_cnt++; last_rd <= mem_addr; end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic take(input logic [7:0] eo, input logic [11:0] ea, input int dly,
                      input logic br, input logic [11:0] tg, input logic sd, input string tag);
    int n = 0;
    while (!iss_valid && n < 50) begin @(negedge clk); n++; end
    chk(iss_valid, {tag, " valid"}, {31'd0, iss_valid}, 1);
    for (int i = 0; i < dly; i++) begin
      // R10: stray branch request while stalled must be ignored
      iss_ready = 1'b0; br_valid = 1'b1; br_target = 12'h555; br_right = 1'b1;
      @(negedge clk);
      chk(iss_valid && iss_opcode == eo && iss_addr == ea, "R6 hold",
          {iss_opcode, 12'd0, iss_addr}, {eo, 12'd0, ea});
    end
    chk(iss_opcode == eo && iss_addr == ea, tag, {iss_opcode, 12'd0, iss_addr}, {eo, 12'd0, ea});
    iss_ready = 1'b1; br_valid = br; br_target = tg; br_right = sd;
    @(negedge clk);
    iss_ready = 1'b0; br_valid = 1'b0;
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk(!iss_valid && !mem_rd, "R1 reset idle", {30'd0, iss_valid, mem_rd}, 0);
    rst = 1'b0;
    while (!mem_rd) @(negedge clk);
    chk(mem_addr == 12'h000, "R1 first read", mem_addr, 0);

    for (int w = 0; w < 16; w++) begin
      take(lop(12'(w)), lad(12'(w)), w % 3, 1'b0, 12'h0, 1'b0, "R2 R3 left");
      take(rop(12'(w)), rad(12'(w)), (w + 1) % 3, 1'b0, 12'h0, 1'b0, "R3 right");
      chk(rd_cnt == w + 1, "R3 R4 read count", rd_cnt, w + 1);
      chk(last_rd == 12'(w), "R4 R5 read address", last_rd, w);
    end

    take(lop(12'd16), lad(12'd16), 1, 1'b0, 12'h0, 1'b0, "R4 left");
    take(rop(12'd16), rad(12'd16), 0, 1'b1, 12'h7F0, 1'b0, "R4 right");
    take(lop(12'h7F0), lad(12'h7F0), 2, 1'b0, 12'h0, 1'b0, "R7 target left");
    take(rop(12'h7F0), rad(12'h7F0), 0, 1'b0, 12'h0, 1'b0, "R7 target right");
    take(lop(12'h7F1), lad(12'h7F1), 0, 1'b0, 12'h0, 1'b0, "R7 after target");
    take(rop(12'h7F1), rad(12'h7F1), 1, 1'b0, 12'h0, 1'b0, "R7 after target right");

    take(lop(12'h7F2), lad(12'h7F2), 0, 1'b1, 12'h123, 1'b1, "R9 branch from left");
    base = rd_cnt;
    take(rop(12'h123), rad(12'h123), 1, 1'b0, 12'h0, 1'b0, "R8 R9 right half only");
    chk(rd_cnt == base + 1, "R8 one read", rd_cnt, base + 1);
    chk(last_rd == 12'h123, "R8 target read", last_rd, 12'h123);
    take(lop(12'h124), lad(12'h124), 0, 1'b0, 12'h0, 1'b0, "R8 continue");
    take(rop(12'h124), rad(12'h124), 0, 1'b1, 12'hFFF, 1'b0, "R8 continue right");

    take(lop(12'hFFF), lad(12'hFFF), 0, 1'b0, 12'h0, 1'b0, "R7 top left");
    take(rop(12'hFFF), rad(12'hFFF), 0, 1'b0, 12'h0, 1'b0, "R7 top right");
    take(lop(12'h000), lad(12'h000), 0, 1'b0, 12'h0, 1'b0, "R4 wrap");
    take(rop(12'h000), rad(12'h000), 2, 1'b1, 12'hFFF, 1'b1, "R4 wrap right");
    take(rop(12'hFFF), rad(12'hFFF), 0, 1'b0, 12'h0, 1'b0, "R8 top right");
    take(lop(12'h000), lad(12'h000), 0, 1'b0, 12'h0, 1'b0, "R8 R4 wrap after right");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule